// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block is a parameterized cache placed between a single-byte processor request port and a main-memory port that moves whole blocks. Storage is arranged as 2^SET_BITS sets, each holding 2^WAY_BITS lines of 2^OFF_BITS bytes. The total data capacity is sets × ways × block bytes. A request address is cut into three fields: the block offset in the low OFF_BITS bits, the set index in the next SET_BITS bits, and the tag in the remaining upper bits. All ways of the indexed set are compared in one cycle. A hit is answered directly from the line. A miss fetches the block from memory, and a dirty victim is first written back when the write-back policy is selected.

A compile-time parameter picks one of two write-policy pairings. The first is write-back with write-allocate, which uses a dirty bit per line. The second is write-through without allocate. Victims are chosen least-recently-used, and an empty way is always taken before an occupied one. Two saturating counters track accepted requests and misses. The miss rate is the ratio of the two. A synchronous clear input zeroes both counters.

Top module: `cache`

## Requirements
- R1: Address bits [OFF_BITS-1:0] select the byte inside the block, the next SET_BITS bits select the set, and the upper bits form the tag. Every read returns the byte most recently written to that address, or the memory byte if it was never written.
- R2: A request hits only when some way of its set is valid and holds an equal tag. `resp_hit` is 1 for a hit and 0 for a miss.
- R3: A hit, other than a write-through write, answers with `resp_valid` in the cycle after acceptance and causes no memory transfer.
- R4: On a block fetch, `mem_addr` equals the request address shifted right by OFF_BITS. The response follows one cycle after the final `mem_ack`, and `req_ready` stays low until then. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R5: With one way per set, a miss replaces the resident line. With 4-bit addresses, 2-byte blocks and 4 sets, the reads 0,1,7,8,0 give miss, hit, miss, miss, miss.
- R6: With several ways, the victim is the lowest-numbered invalid way, or else the least recently used way. With 4-bit addresses, 2-byte blocks, 2 sets and 2 ways, the reads 0,1,7,8,0 give miss, hit, miss, miss, hit.
- R7: In write-back mode a write hit changes only the cached line, marks it dirty and performs no memory write.
- R8: In write-back mode, evicting a dirty line first writes its whole block (`mem_be` all ones) to the victim's block address, holding the latest data. A clean victim causes no write.
- R9: In write-back mode a write miss fetches the block, merges the byte and leaves the line dirty, so a following read of that block hits.
- R10: In write-through mode every write produces exactly one memory write. That write has `mem_be` = 1 << offset and the data byte at that offset, and a write hit also updates the line.
- R11: In write-through mode a write miss allocates no line, so a following read of that block misses. Memory always equals the latest written data.
- R12: `stat_access` counts accepted requests and `stat_miss` counts the misses among them. Both saturate at all ones. `stat_clear` zeroes both on the next edge and takes priority over counting.
- R13: After reset all lines are invalid, both counters read 0, `req_ready` is 1 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Read byte |
| resp_hit | output | 1 | Completed request was a hit |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W-OFF_BITS | Block address |
| mem_be | output | 2^OFF_BITS | Byte enables of a write |
| mem_wdata | output | 8·2^OFF_BITS | Write block |
| mem_rdata | input | 8·2^OFF_BITS | Read block, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes at this edge |
| stat_clear | input | 1 | Clear both counters |
| stat_access | output | CNT_W | Accepted request count |
| stat_miss | output | CNT_W | Miss count |

## Verification
A hit response appears in the cycle right after the accepting edge. A miss raises `mem_req` in that cycle and answers one cycle after the last `mem_ack`. The counters move at the accepting edge, and a clear takes effect at the edge after `stat_clear`. The bench drives on falling edges and samples every output on the falling edge that follows the edge in question. It records the falling-edge index at which each instance was accepted and at which it answered, so hit latency is checked as an exact difference of one. Three instances receive the same stimulus: set-associative write-back, direct-mapped write-back and set-associative write-through. Each is compared with a timestamp-based model of its own geometry and policy.

// File: rtl/cache.sv
module cache #(
  parameter int ADDR_W     = 12,
  parameter int SET_BITS   = 3,
  parameter int WAY_BITS   = 2,
  parameter int OFF_BITS   = 2,
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_we,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [7:0]                     req_wdata,
  output logic                           req_ready,
  output logic                           resp_valid,
  output logic [7:0]                     resp_rdata,
  output logic                           resp_hit,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [ADDR_W-OFF_BITS-1:0]     mem_addr,
  output logic [(1<<OFF_BITS)-1:0]       mem_be,
  output logic [8*(1<<OFF_BITS)-1:0]     mem_wdata,
  input  logic [8*(1<<OFF_BITS)-1:0]     mem_rdata,
  input  logic                           mem_ack,
  input  logic                           stat_clear,
  output logic [CNT_W-1:0]               stat_access,
  output logic [CNT_W-1:0]               stat_miss
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAYS  = 1 << WAY_BITS;
  localparam int BYTES = 1 << OFF_BITS;
  localparam int BLK_W = 8 * BYTES;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam int BA_W  = ADDR_W - OFF_BITS;
  localparam int SI_W  = SET_BITS > 0 ? SET_BITS : 1;
  localparam int WI_W  = WAY_BITS > 0 ? WAY_BITS : 1;
  localparam int OI_W  = OFF_BITS > 0 ? OFF_BITS : 1;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_THRU} state_t;
  state_t state;

  logic             vld   [SETS][WAYS];
  logic             dirty [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [BLK_W-1:0] blk   [SETS][WAYS];
  logic [WI_W-1:0]  age   [SETS][WAYS];

  logic [ADDR_W-1:0] r_addr;
  logic              r_we, r_hit;
  logic [7:0]        r_wdata;
  logic [WI_W-1:0]   r_way;

  function automatic logic [SI_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return SI_W'((a >> OFF_BITS) & ADDR_W'(SETS - 1));
  endfunction
  function automatic logic [OI_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return OI_W'(a & ADDR_W'(BYTES - 1));
  endfunction
  function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] b,
                                               input logic [OI_W-1:0] o,
                                               input logic [7:0] d);
    logic [BLK_W-1:0] x;
    x = b;
    x[o*8 +: 8] = d;
    return x;
  endfunction

  logic [SI_W-1:0]  in_set, r_set;
  logic [OI_W-1:0]  in_off, r_off;
  logic [TAG_W-1:0] in_tag, r_tag;
  assign in_set = set_of(req_addr);
  assign in_off = off_of(req_addr);
  assign in_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign r_set  = set_of(r_addr);
  assign r_off  = off_of(r_addr);
  assign r_tag  = r_addr[ADDR_W-1 -: TAG_W];

  logic            hit, found;
  logic [WI_W-1:0] hit_way, victim;
  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[in_set][w] && tag_q[in_set][w] == in_tag) begin
        hit = 1'b1;
        hit_way = WI_W'(w);
      end
  end
  always_comb begin
    victim = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !vld[in_set][w]) begin
        victim = WI_W'(w);
        found = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age[in_set][w] == WI_W'(WAYS - 1)) victim = WI_W'(w);
  end

  logic accept;
  assign accept    = req_valid && state == S_IDLE;
  assign req_ready = state == S_IDLE;
  assign mem_req   = state != S_IDLE;
  assign mem_we    = state == S_EVICT || state == S_THRU;
  assign mem_addr  = (state == S_EVICT)
                   ? ((BA_W'(tag_q[r_set][r_way]) << SET_BITS) | BA_W'(r_set))
                   : r_addr[ADDR_W-1:OFF_BITS];
  assign mem_be    = (state == S_THRU) ? BYTES'(1) << r_off : {BYTES{1'b1}};
  assign mem_wdata = (state == S_THRU) ? {BYTES{r_wdata}} : blk[r_set][r_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_rdata  <= '0;
      stat_access <= '0;
      stat_miss   <= '0;
      r_addr      <= '0;
      r_we        <= 1'b0;
      r_hit       <= 1'b0;
      r_wdata     <= '0;
      r_way       <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]   <= 1'b0;
          dirty[s][w] <= 1'b0;
          age[s][w]   <= WI_W'(w);
        end
    end else begin
      resp_valid <= 1'b0;
      if (stat_clear) begin
        stat_access <= '0;
        stat_miss   <= '0;
      end else if (accept) begin
        if (stat_access != '1) stat_access <= stat_access + 1'b1;
        if (!hit && stat_miss != '1) stat_miss <= stat_miss + 1'b1;
      end
      case (state)
        S_IDLE: if (accept) begin
          r_addr  <= req_addr;
          r_we    <= req_we;
          r_wdata <= req_wdata;
          r_hit   <= hit;
          if (hit) begin
            for (int k = 0; k < WAYS; k++)
              if (k == int'(hit_way)) age[in_set][k] <= '0;
              else if (age[in_set][k] < age[in_set][hit_way])
                age[in_set][k] <= age[in_set][k] + 1'b1;
            if (req_we) begin
              blk[in_set][hit_way] <= put_byte(blk[in_set][hit_way], in_off, req_wdata);
              if (WRITE_BACK != 0) dirty[in_set][hit_way] <= 1'b1;
            end else begin
              resp_rdata <= blk[in_set][hit_way][in_off*8 +: 8];
            end
            if (req_we && WRITE_BACK == 0) state <= S_THRU;
            else begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
            end
          end else begin
            r_way <= victim;
            if (req_we && WRITE_BACK == 0) state <= S_THRU;
            else if (vld[in_set][victim] && dirty[in_set][victim]) state <= S_EVICT;
            else state <= S_FILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          dirty[r_set][r_way] <= 1'b0;
          state <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          vld[r_set][r_way]   <= 1'b1;
          tag_q[r_set][r_way] <= r_tag;
          dirty[r_set][r_way] <= r_we;
          blk[r_set][r_way]   <= r_we ? put_byte(mem_rdata, r_off, r_wdata) : mem_rdata;
          for (int k = 0; k < WAYS; k++)
            if (k == int'(r_way)) age[r_set][k] <= '0;
            else if (age[r_set][k] < age[r_set][r_way])
              age[r_set][k] <= age[r_set][k] + 1'b1;
          resp_rdata <= mem_rdata[r_off*8 +: 8];
          resp_hit   <= 1'b0;
          resp_valid <= 1'b1;
          state      <= S_IDLE;
        end
        S_THRU: if (mem_ack) begin
          resp_hit   <= r_hit;
          resp_valid <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W     = 12,
  parameter int OFF_BITS   = 2,
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       resp_valid,
  input logic                       resp_hit,
  input logic                       mem_req,
  input logic                       mem_we,
  input logic [ADDR_W-OFF_BITS-1:0] mem_addr,
  input logic [(1<<OFF_BITS)-1:0]   mem_be,
  input logic                       mem_ack,
  input logic                       stat_clear,
  input logic [CNT_W-1:0]           stat_access,
  input logic [CNT_W-1:0]           stat_miss
);
  // R3: a hit not closed by a memory write answers one cycle after acceptance
  p_hit_latency_r3: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_hit && !$past(mem_ack) |-> $past(req_valid && req_ready));

  // R4: memory request held stable until acknowledged
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R8 and R10: byte enables follow the write policy
  p_mem_be_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> (WRITE_BACK != 0 ? (&mem_be) : $onehot(mem_be)));

  // R12: clear zeroes both counters on the next edge
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    stat_clear |=> stat_access == '0 && stat_miss == '0);

  // R12: misses never outnumber accesses
  p_miss_le_r12: assert property (@(posedge clk) disable iff (rst)
    stat_miss <= stat_access);

  // R12: a saturated access counter holds unless cleared
  p_saturate_r12: assert property (@(posedge clk) disable iff (rst)
    stat_access == '1 && !stat_clear |=> stat_access == '1);
endmodule

bind cache cache_chk #(
  .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .WRITE_BACK(WRITE_BACK), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_ack(mem_ack), .stat_clear(stat_clear),
  .stat_access(stat_access), .stat_miss(stat_miss)
);

// File: tb/test_cache.sv
module test_cache;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0] rv = '0;
  logic       rwe = 1'b0;
  logic [3:0] raddr = '0;
  logic [7:0] rwd = '0;
  logic       sclr = 1'b0;
  logic [2:0] rdy, rsp, rhit, mreq, mwe;
  logic [2:0] mack = '0;
  logic [7:0] rdat [3];
  logic [2:0] maddr [3];
  logic [1:0] mbe [3];
  logic [15:0] mwd [3];
  logic [15:0] mrd [3];
  logic [5:0] sacc [3], smiss [3];

  cache #(.ADDR_W(4), .SET_BITS(1), .WAY_BITS(1), .OFF_BITS(1), .WRITE_BACK(1), .CNT_W(6)) i_cache (
    .clk(clk), .rst(rst), .req_valid(rv[0]), .req_we(rwe), .req_addr(raddr), .req_wdata(rwd),
    .req_ready(rdy[0]), .resp_valid(rsp[0]), .resp_rdata(rdat[0]), .resp_hit(rhit[0]),
    .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_be(mbe[0]), .mem_wdata(mwd[0]),
    .mem_rdata(mrd[0]), .mem_ack(mack[0]), .stat_clear(sclr), .stat_access(sacc[0]), .stat_miss(smiss[0]));
  cache #(.ADDR_W(4), .SET_BITS(2), .WAY_BITS(0), .OFF_BITS(1), .WRITE_BACK(1), .CNT_W(6)) i_cache_dm (
    .clk(clk), .rst(rst), .req_valid(rv[1]), .req_we(rwe), .req_addr(raddr), .req_wdata(rwd),
    .req_ready(rdy[1]), .resp_valid(rsp[1]), .resp_rdata(rdat[1]), .resp_hit(rhit[1]),
    .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_be(mbe[1]), .mem_wdata(mwd[1]),
    .mem_rdata(mrd[1]), .mem_ack(mack[1]), .stat_clear(sclr), .stat_access(sacc[1]), .stat_miss(smiss[1]));
  cache #(.ADDR_W(4), .SET_BITS(1), .WAY_BITS(1), .OFF_BITS(1), .WRITE_BACK(0), .CNT_W(6)) i_cache_wt (
    .clk(clk), .rst(rst), .req_valid(rv[2]), .req_we(rwe), .req_addr(raddr), .req_wdata(rwd),
    .req_ready(rdy[2]), .resp_valid(rsp[2]), .resp_rdata(rdat[2]), .resp_hit(rhit[2]),
    .mem_req(mreq[2]), .mem_we(mwe[2]), .mem_addr(maddr[2]), .mem_be(mbe[2]), .mem_wdata(mwd[2]),
    .mem_rdata(mrd[2]), .mem_ack(mack[2]), .stat_clear(sclr), .stat_access(sacc[2]), .stat_miss(smiss[2]));

  int nchk = 0, nerr = 0;
  int nsets [3] = '{2, 4, 2};
  int nways [3] = '{2, 1, 2};
  bit wbm [3]   = '{1'b1, 1'b1, 1'b0};
  bit mv [3][4][2];
  bit md [3][4][2];
  int mt [3][4][2];
  int mu [3][4][2];
  int stamp = 0;
  bit [7:0] gold [16];
  bit [7:0] bmem [3][16];
  int wcnt [3];
  int lat [3];
  int cur_addr = 0, cur_data = 0;
  int nacc = 0;
  int nmiss [3];

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural memory with a two-edge response delay
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (mack[i]) mack[i] = 1'b0;
      else if (mreq[i]) begin
        if (lat[i] == 0) lat[i] = 1;
        else begin
          lat[i] = 0;
          mack[i] = 1'b1;
          if (mwe[i]) begin
            wcnt[i]++;
            if (wbm[i]) begin
              chk(mbe[i] == 2'b11, "R8", int'(mbe[i]), 3);
              chk(mwd[i] == {gold[2*maddr[i]+1], gold[2*maddr[i]]}, "R8", int'(mwd[i]),
                  int'({gold[2*maddr[i]+1], gold[2*maddr[i]]}));
            end else begin
              chk(mbe[i] == 2'(1 << (cur_addr & 1)), "R10", int'(mbe[i]), 1 << (cur_addr & 1));
              chk(mwd[i][8*(cur_addr & 1) +: 8] == 8'(cur_data), "R10",
                  int'(mwd[i][8*(cur_addr & 1) +: 8]), cur_data);
            end
            for (int k = 0; k < 2; k++)
              if (mbe[i][k]) bmem[i][2*maddr[i]+k] = mwd[i][8*k +: 8];
          end else begin
            chk(int'(maddr[i]) == (cur_addr >> 1), "R4", int'(maddr[i]), cur_addr >> 1);
            mrd[i] = {bmem[i][2*maddr[i]+1], bmem[i][2*maddr[i]]};
          end
        end
      end
    end
  end

  task automatic model(int i, bit we, int a, output bit h, output int nw);
    int b, s, t, hw, vw;
    b = a >> 1; s = b % nsets[i]; t = b / nsets[i]; hw = -1; vw = -1;
    stamp++;
    for (int w = 0; w < nways[i]; w++)
      if (mv[i][s][w] && mt[i][s][w] == t) hw = w;
    if (hw >= 0) begin
      h = 1'b1;
      mu[i][s][hw] = stamp;
      if (we && wbm[i]) md[i][s][hw] = 1'b1;
      nw = (we && !wbm[i]) ? 1 : 0;
    end else begin
      h = 1'b0;
      if (we && !wbm[i]) nw = 1;
      else begin
        for (int w = 0; w < nways[i]; w++)
          if (vw < 0 && !mv[i][s][w]) vw = w;
        if (vw < 0) begin
          vw = 0;
          for (int w = 1; w < nways[i]; w++)
            if (mu[i][s][w] < mu[i][s][vw]) vw = w;
        end
        nw = (mv[i][s][vw] && md[i][s][vw]) ? 1 : 0;
        mv[i][s][vw] = 1'b1; mt[i][s][vw] = t; md[i][s][vw] = we; mu[i][s][vw] = stamp;
      end
    end
  endtask

  task automatic step(bit we, int a, int d, output bit [2:0] hits);
    bit eh [3];
    int ew [3];
    int ait [3], rit [3];
    bit [7:0] rd [3];
    bit [2:0] v, got, pend, busy_bad;
    int it;
    for (int i = 0; i < 3; i++) begin
      model(i, we, a, eh[i], ew[i]);
      wcnt[i] = 0;
    end
    cur_addr = a; cur_data = d;
    @(negedge clk);
    rwe = we; raddr = 4'(a); rwd = 8'(d);
    v = 3'b111; got = '0; it = 0; busy_bad = '0;
    pend = v & rdy;
    for (int i = 0; i < 3; i++) if (pend[i]) ait[i] = 0;
    rv = v;
    while (got != 3'b111 && it < 200) begin
      @(negedge clk);
      it++;
      for (int i = 0; i < 3; i++)
        if (rsp[i]) begin
          got[i] = 1'b1; hits[i] = rhit[i]; rd[i] = rdat[i]; rit[i] = it;
        end
      v = v & ~pend;
      for (int i = 0; i < 3; i++)
        if (!v[i] && !got[i] && rdy[i]) busy_bad[i] = 1'b1;
      pend = v & rdy;
      for (int i = 0; i < 3; i++) if (pend[i]) ait[i] = it;
      rv = v;
    end
    rv = '0;
    for (int i = 0; i < 3; i++) begin
      chk(got[i], "R4 response", int'(got[i]), 1);
      chk(!busy_bad[i], "R4 ready low while busy", int'(busy_bad[i]), 0);
      chk(hits[i] == eh[i], nways[i] == 1 ? "R5 hit/miss" : "R2 R6 hit/miss", int'(hits[i]), int'(eh[i]));
      if (!we) chk(rd[i] == gold[a], "R1 read data", int'(rd[i]), int'(gold[a]));
      chk(wcnt[i] == ew[i], wbm[i] ? "R7 R8 R9 write count" : "R10 R11 write count", wcnt[i], ew[i]);
      if (hits[i] && !(we && !wbm[i])) chk(rit[i] == ait[i] + 1, "R3 hit latency", rit[i] - ait[i], 1);
      if (!eh[i]) nmiss[i]++;
    end
    nacc++;
    if (we) gold[a] = 8'(d);
  endtask

  task automatic clear_stats();
    @(negedge clk); sclr = 1'b1;
    @(negedge clk); sclr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(sacc[i] == 0 && smiss[i] == 0, "R12 clear", int'(sacc[i]) + int'(smiss[i]), 0);
      nmiss[i] = 0;
    end
    nacc = 0;
  endtask

  task automatic stats_check();
    for (int i = 0; i < 3; i++) begin
      chk(int'(sacc[i]) == (nacc > 63 ? 63 : nacc), "R12 accesses", int'(sacc[i]), nacc > 63 ? 63 : nacc);
      chk(int'(smiss[i]) == (nmiss[i] > 63 ? 63 : nmiss[i]), "R12 misses", int'(smiss[i]),
          nmiss[i] > 63 ? 63 : nmiss[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int tr [5] = '{0, 1, 7, 8, 0};
    bit esa [5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    bit edm [5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    bit [2:0] h;
    int unsigned x = 32'd12345;
    for (int a = 0; a < 16; a++) begin
      gold[a] = 8'(a * 37 + 5);
      for (int i = 0; i < 3; i++) bmem[i][a] = 8'(a * 37 + 5);
    end
    for (int i = 0; i < 3; i++) begin
      lat[i] = 0; wcnt[i] = 0; nmiss[i] = 0; mrd[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(rdy == 3'b111, "R13 ready", int'(rdy), 7);
    chk(rsp == 3'b000, "R13 resp_valid", int'(rsp), 0);
    for (int i = 0; i < 3; i++)
      chk(sacc[i] == 0 && smiss[i] == 0, "R13 counters", int'(sacc[i]) + int'(smiss[i]), 0);

    // trace from a cold cache: R6 for two ways, R5 for direct mapping
    for (int k = 0; k < 5; k++) begin
      step(1'b0, tr[k], 0, h);
      chk(h[0] == esa[k], "R6 trace", int'(h[0]), int'(esa[k]));
      chk(h[1] == edm[k], "R5 trace", int'(h[1]), int'(edm[k]));
    end
    chk(smiss[0] == 3, "R12 trace misses", int'(smiss[0]), 3);
    chk(smiss[1] == 4, "R12 trace misses", int'(smiss[1]), 4);
    stats_check();
    clear_stats();

    // R9 and R11: write miss then read of the same block
    step(1'b1, 12, 8'h3C, h);
    step(1'b0, 13, 0, h);
    chk(h[0] == 1'b1, "R9 allocate on write miss", int'(h[0]), 1);
    chk(h[2] == 1'b0, "R11 no allocate", int'(h[2]), 0);

    // sweep: write every address, then read every address
    for (int a = 0; a < 16; a++) step(1'b1, a, (a * 11) ^ 8'hA5, h);
    for (int a = 0; a < 16; a++) step(1'b0, a, 0, h);

    // mixed pseudo-random traffic
    for (int n = 0; n < 160; n++) begin
      x = x * 32'd1103515245 + 32'd12345;
      step(x[20], int'(x[27:24]), int'(x[15:8]), h);
    end
    stats_check();
    clear_stats();

    // R11: write-through memory always current
    for (int a = 0; a < 16; a++)
      chk(bmem[2][a] == gold[a], "R11 memory image", int'(bmem[2][a]), int'(gold[a]));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule